// File: doc/BRIEF.md
# Sparse-Decode Modulo Event Divider

This block turns a slow, free-running square wave into a much slower tick. The wave is sampled into the fast system clock domain, and every high-to-low transition advances a 12-bit binary event counter by one. A small decoder looks only at the counter bits that are set in a mask parameter. When the next count would have all of those bits high, the counter returns to zero instead and a single one-cycle tick is emitted. The division ratio is therefore the mask value itself. With the default mask (weights 16, 512, 1024 and 2048, total 3600), a 60 Hz input gives one tick per minute.

An external active-high reset clears the counter, the input synchronizer and the edge history. Its assertion is asynchronous and its release is aligned to the system clock. The counter value is visible on an output port, so a neighbour can take an intermediate rate from any bit.

Top module: `modDivider`

## Requirements
- R1: While `rstIn` is high and for the cycles just after its release, `countOut` is 0 and `tickOut` is 0.
- R2: Each high-to-low transition of `evtIn`, held steady for at least three system clocks on each side, raises `countOut` by exactly one. A low-to-high transition leaves `countOut` unchanged.
- R3: `countOut` never exceeds the modulus minus one. The modulus equals the value of the mask parameter, 3600 by default, so the largest count is 3599.
- R4: `tickOut` is high for exactly one system clock per modulus input falling edges. The first tick after reset follows falling edge number 3600, and each later tick follows a further 3600 edges.
- R5: In the clock where `tickOut` is high, `countOut` reads 0. The counter goes from 3599 straight to 0 and never shows a count whose masked bits are all set.
- R6: With `evtIn` held at a constant level, `countOut` keeps its value.
- R7: Raising `rstIn` clears `countOut` at once, without waiting for a clock edge. Counting then restarts, so the next tick comes 3600 falling edges after the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstIn | input | 1 | Active-high reset, asynchronous assertion |
| evtIn | input | 1 | Slow event wave, asynchronous to clk; falling edges are counted |
| tickOut | output | 1 | One-clock pulse each time the modulus is completed |
| countOut | output | 12 | Current event count, bit 0 least significant |

## Verification
The bench builds the block with its defaults: a 12-bit counter, mask 0xE10 and a two-stage synchronizer. These values bring the full 3600-edge cycle within reach in a short run. That cycle includes the carries into bits 9, 10 and 11, where a full-equality design and a sparse decode would differ if the mask logic were wrong. Two whole cycles and a reset in mid-count are run, so both the self-clear path and the external clear path are exercised against the same expected tick positions.

// File: rtl/divPkg.sv
package divPkg;
  // strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic countEn;   // a falling edge was seen on the event input
    logic wrapCnt;   // this edge completes the modulus: load zero
  } ctrlStrobes_t;
endpackage

// File: rtl/divRstSync.sv
module divRstSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstAsync,
  output logic rstSys
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) chain <= '1;
    else          chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rstSys = chain[STAGES-1];
endmodule

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int             CNT_W       = 12,
  parameter logic [CNT_W-1:0] MASK      = 12'hE10,
  parameter int             SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstSys,
  input  logic             evtIn,
  input  logic [CNT_W-1:0] countQ,
  output ctrlStrobes_t     strobes,
  output logic             tickOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   evtPrev;
  logic                   fallEdge;
  logic [CNT_W-1:0]       countNext;
  logic [CNT_W-1:0]       bitHit;
  logic                   hitTerm;
  logic                   tickQ;

  // input synchronizer and edge history
  always_ff @(posedge clk or posedge rstSys) begin
    if (rstSys) begin
      syncChain <= '0;
      evtPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], evtIn};
      evtPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign fallEdge  = evtPrev & ~syncChain[SYNC_STAGES-1];
  assign countNext = countQ + 1'b1;

  // sparse decode: only mask bits take part, the others are don't-care
  for (genvar i = 0; i < CNT_W; i++) begin : g_dec
    if (MASK[i]) begin : g_use
      assign bitHit[i] = countNext[i];
    end else begin : g_skip
      assign bitHit[i] = 1'b1;
    end
  end
  assign hitTerm = &bitHit;

  always_comb begin
    strobes.countEn = fallEdge;
    strobes.wrapCnt = fallEdge & hitTerm;
  end

  always_ff @(posedge clk or posedge rstSys) begin
    if (rstSys) tickQ <= 1'b0;
    else        tickQ <= strobes.wrapCnt;
  end

  assign tickOut = tickQ;
endmodule

// File: rtl/divCounter.sv
module divCounter
  import divPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstSys,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] countQ
);
  always_ff @(posedge clk or posedge rstSys) begin
    if (rstSys)               countQ <= '0;
    else if (strobes.wrapCnt) countQ <= '0;
    else if (strobes.countEn) countQ <= countQ + 1'b1;
  end
endmodule

// File: rtl/modDivider.sv
module modDivider
  import divPkg::*;
#(
  parameter int               CNT_W       = 12,
  parameter logic [CNT_W-1:0] MASK        = 12'hE10,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstIn,
  input  logic             evtIn,
  output logic             tickOut,
  output logic [CNT_W-1:0] countOut
);
  logic         rstSys;
  ctrlStrobes_t strobes;
  logic [CNT_W-1:0] countQ;

  divRstSync #(.STAGES(2)) uRst (
    .clk(clk), .rstAsync(rstIn), .rstSys(rstSys)
  );

  divCtrl #(.CNT_W(CNT_W), .MASK(MASK), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstSys(rstSys), .evtIn(evtIn), .countQ(countQ),
    .strobes(strobes), .tickOut(tickOut)
  );

  divCounter #(.CNT_W(CNT_W)) uCnt (
    .clk(clk), .rstSys(rstSys), .strobes(strobes), .countQ(countQ)
  );

  assign countOut = countQ;
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int               CNT_W = 12,
  parameter logic [CNT_W-1:0] MASK  = 12'hE10
) (
  input logic             clk,
  input logic             rstIn,
  input logic             tickOut,
  input logic [CNT_W-1:0] countOut
);
  // R3: count stays below the modulus
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rstIn)
    countOut < MASK);

  // R4: tick lasts a single clock
  p_tick_single_r4: assert property (@(posedge clk) disable iff (rstIn)
    tickOut |=> !tickOut);

  // R5: tick coincides with the counter back at zero
  p_tick_zero_r5: assert property (@(posedge clk) disable iff (rstIn)
    tickOut |-> (countOut == '0));

  // R2, R6: any change without a tick is a step of one
  p_step_one_r2: assert property (@(posedge clk) disable iff (rstIn)
    (!tickOut && countOut != $past(countOut)) |-> countOut == $past(countOut) + 1'b1);

  // R1: no tick while the count is held at zero by reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rstIn |-> (!tickOut && countOut == '0));
endmodule

bind modDivider divChecker #(.CNT_W(CNT_W), .MASK(MASK)) uChk (
  .clk(clk), .rstIn(rstIn), .tickOut(tickOut), .countOut(countOut)
);

// File: tb/sim_modDivider.sv
module sim_modDivider;
  localparam int MODV = 3600;

  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic evtIn = 1'b0;
  logic tickOut;
  logic [11:0] countOut;

  int errs = 0;
  int checks = 0;
  int edgeIdx = 0;
  int tickSeen = 0;
  int maxCnt = 0;
  int expQ[$];
  logic prevTick = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modDivider u0 (
    .clk(clk), .rstIn(rstIn), .evtIn(evtIn),
    .tickOut(tickOut), .countOut(countOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // driver: one full period of the event wave, expected tick queued
  task automatic pulseEdge();
    @(negedge clk) evtIn = 1'b1;
    repeat (4) @(negedge clk);
    evtIn = 1'b0;
    edgeIdx++;
    if (edgeIdx % MODV == 0) expQ.push_back(edgeIdx);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expected tick positions as ticks appear
  always @(negedge clk) begin
    if (!rstIn) begin
      if (int'(countOut) > maxCnt) maxCnt = int'(countOut);
      if (tickOut) begin
        tickSeen++;
        chk(!prevTick, "R4 tick width", 2, 1);
        if (expQ.size() == 0) chk(1'b0, "R4 unexpected tick", edgeIdx, 0);
        else begin
          int e;
          e = expQ.pop_front();
          chk(e == edgeIdx, "R4 tick position", edgeIdx, e);
        end
        chk(countOut == 12'd0, "R5 count at tick", int'(countOut), 0);
      end
      prevTick = tickOut;
    end else prevTick = 1'b0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int held;
    repeat (5) @(negedge clk);
    chk(countOut == 12'd0, "R1 count in reset", int'(countOut), 0);
    chk(tickOut == 1'b0, "R1 tick in reset", int'(tickOut), 0);
    rstIn = 1'b0;
    @(negedge clk);
    chk(countOut == 12'd0 && !tickOut, "R1 after release", int'(countOut), 0);
    repeat (4) @(negedge clk);

    for (int k = 1; k <= 3; k++) begin
      pulseEdge();
      chk(int'(countOut) == k, "R2 one step per falling edge", int'(countOut), k);
    end
    // rising edge alone
    evtIn = 1'b1;
    repeat (6) @(negedge clk);
    chk(int'(countOut) == 3, "R2 rising edge ignored", int'(countOut), 3);
    held = int'(countOut);
    repeat (50) @(negedge clk);
    chk(int'(countOut) == held, "R6 hold on high level", int'(countOut), held);
    evtIn = 1'b0;
    edgeIdx++;
    repeat (4) @(negedge clk);
    chk(int'(countOut) == 4, "R2 falling edge after long high", int'(countOut), 4);
    repeat (50) @(negedge clk);
    chk(int'(countOut) == 4, "R6 hold on low level", int'(countOut), 4);

    while (edgeIdx < 2*MODV) begin
      pulseEdge();
      if (edgeIdx == MODV - 1)
        chk(int'(countOut) == MODV - 1, "R3 count before wrap", int'(countOut), MODV - 1);
    end
    chk(countOut == 12'd0, "R5 count after second cycle", int'(countOut), 0);
    chk(tickSeen == 2, "R4 ticks in two cycles", tickSeen, 2);

    for (int k = 0; k < 100; k++) pulseEdge();
    chk(int'(countOut) == 100, "R2 count before reset", int'(countOut), 100);
    @(negedge clk) rstIn = 1'b1;
    #1;
    chk(countOut == 12'd0, "R7 async clear", int'(countOut), 0);
    repeat (3) @(negedge clk);
    rstIn = 1'b0;
    edgeIdx = 0;
    repeat (4) @(negedge clk);
    while (edgeIdx < MODV) pulseEdge();
    repeat (4) @(negedge clk);
    chk(tickSeen == 3, "R7 tick after restart", tickSeen, 3);
    chk(expQ.size() == 0, "R4 all expected ticks seen", expQ.size(), 0);
    chk(maxCnt == MODV - 1, "R3 largest count", maxCnt, MODV - 1);
    finishRun();
  end
endmodule